// File: doc/BRIEF.md
# PCI address phase decoder

This block sits on a conventional parallel PCI bus next to a bridge-style target. It watches the frame signal, the multiplexed address/data lines and the command/byte-enable lines. From these it finds the start of each transaction and captures its address. The address is 32 bits wide when it is carried in one address phase and 64 bits wide when it is carried in two. The block then decides whether the target behind it should claim the transaction.

The decision depends on the bus command and on the side of the bridge the block serves. That side is fixed by a parameter. For each transaction the block gives one registered result pulse, which carries:
- the claim decision,
- the effective command,
- the full address,
- a flag for a configuration Type 1 access,
- a flag saying the target must stop after the first data transfer because the burst order is not linear.

Data phases, handshaking, address windows and parity belong to other blocks.

Top module: `pci_addr_decode`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, all result outputs are 0. A `frame_n` that is low during reset, or still low when reset is released, starts no transaction. A start is only recognised after `frame_n` has been sampled high.
- R2: Single address cycle. The clock edge at which `frame_n` is first sampled low, after having been sampled high, is the address phase. When `cbe_n` is not 1101 on that edge, `res_valid` is high for the clock that follows it. `res_cmd` then equals the sampled `cbe_n`, `res_addr[31:0]` equals the sampled `ad`, and `res_addr[63:32]` is 0.
- R3: Dual address cycle. When the first-phase command is 1101, no pulse follows the first phase. `ad` on the next clock edge gives the upper 32 address bits and `cbe_n` on that edge gives the command. `res_valid` is high for the clock after that second edge, with `res_addr = {second ad, first ad}`.
- R4: `res_valid` is never high for two consecutive clocks. Keeping `frame_n` low after an address phase produces no further pulse.
- R5: The reserved command codes 0100, 0101, 1000 and 1001 never give `res_claim = 1`.
- R6: Interrupt acknowledge (0000) and special cycle (0001) never give `res_claim = 1`.
- R7: I/O read (0010), I/O write (0011), memory read (0110), memory write (0111), memory read multiple (1100), memory read line (1110) and memory write and invalidate (1111) are claimed on both sides, whatever the address bits [1:0] are.
- R8: Configuration read (1010) and configuration write (1011) use address bits [1:0] as the configuration type, and `res_cfg_t1 = 1` exactly when those bits are 01. With `SECONDARY = 0`, types 00 and 01 are claimed. With `SECONDARY = 1`, only type 01 is claimed. The encodings 10 and 11 are never claimed.
- R9: `res_disc = 1` exactly when the command is a memory command (0110, 0111, 1100, 1110, 1111) and address bits [1:0] are not 00. It is never 1 for I/O or configuration commands.
- R10: A second-phase command of 1101 is reported in `res_cmd` but is not claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | Frame signal, active low |
| ad | input | AD_W (32) | Multiplexed address/data lines |
| cbe_n | input | 4 | Command / byte-enable lines; the command code as driven on the pins |
| res_valid | output | 1 | One-clock pulse per decoded transaction |
| res_claim | output | 1 | The target should claim this transaction |
| res_cmd | output | 4 | Effective bus command |
| res_addr | output | 2*AD_W (64) | Captured address; upper half is 0 for a single address cycle |
| res_cfg_t1 | output | 1 | Configuration access of Type 1 |
| res_disc | output | 1 | Disconnect after the first data transfer (non-linear burst order) |

## Verification
The hardest case to reach is the dual address cycle. There the result depends on two consecutive edges, and the command that decides the claim is not the one that marked the start. The bench drives that two-edge sequence for every second-phase command combined with every low address pattern. This includes 1101 repeated in the second phase, and it checks that no pulse appears between the two phases. It also reaches a start masked by reset, by holding the frame signal low across the reset release, and a frame held low past its address phase.

// File: rtl/pci_dec_pkg.sv
package pci_dec_pkg;

   typedef enum logic [3:0] {
      CMD_INTACK  = 4'h0,
      CMD_SPECIAL = 4'h1,
      CMD_IO_RD   = 4'h2,
      CMD_IO_WR   = 4'h3,
      CMD_RSV4    = 4'h4,
      CMD_RSV5    = 4'h5,
      CMD_MEM_RD  = 4'h6,
      CMD_MEM_WR  = 4'h7,
      CMD_RSV8    = 4'h8,
      CMD_RSV9    = 4'h9,
      CMD_CFG_RD  = 4'hA,
      CMD_CFG_WR  = 4'hB,
      CMD_MEM_RDM = 4'hC,
      CMD_DUAL    = 4'hD,
      CMD_MEM_RDL = 4'hE,
      CMD_MEM_WRI = 4'hF
   } bus_cmd_e;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_IO   = 2'd1,
      CLS_MEM  = 2'd2,
      CLS_CFG  = 2'd3
   } cmd_class_e;

   typedef enum logic {
      TRK_IDLE = 1'b0,
      TRK_HIGH = 1'b1
   } trk_state_e;

   typedef struct packed {
      logic claim;
      logic cfg_t1;
      logic disc;
   } verdict_t;

   localparam int CMD_W = 4;

   function automatic cmd_class_e classify(input logic [CMD_W-1:0] c);
      cmd_class_e k;
      case (c)
         CMD_IO_RD, CMD_IO_WR:                       k = CLS_IO;
         CMD_MEM_RD, CMD_MEM_WR, CMD_MEM_RDM,
         CMD_MEM_RDL, CMD_MEM_WRI:                   k = CLS_MEM;
         CMD_CFG_RD, CMD_CFG_WR:                     k = CLS_CFG;
         default:                                    k = CLS_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/pci_phase_track.sv
module pci_phase_track
   import pci_dec_pkg::*;
#(
   parameter int AD_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_n,
   input  logic [AD_W-1:0]      ad,
   input  logic [CMD_W-1:0]     cbe_n,
   output logic                 go,
   output logic [CMD_W-1:0]     go_cmd,
   output logic [AD_W-1:0]      go_lo,
   output logic [AD_W-1:0]      go_hi
);

   logic            frame_q;
   trk_state_e      st_q, st_d;
   logic [AD_W-1:0] lo_q;
   logic            start;
   logic            first_dual;

   // Sampled frame level follows the pin also during reset, so a
   // frame held low across reset release needs a high sample first.
   always_ff @(posedge clk) frame_q <= frame_n;

   assign start      = (st_q == TRK_IDLE) && frame_q && !frame_n;
   assign first_dual = start && (cbe_n == CMD_DUAL);

   always_comb begin
      st_d   = st_q;
      go     = 1'b0;
      go_cmd = cbe_n;
      go_lo  = ad;
      go_hi  = '0;
      case (st_q)
         TRK_IDLE: begin
            if (first_dual)      st_d = TRK_HIGH;
            else if (start)      go   = 1'b1;
         end
         TRK_HIGH: begin
            go    = 1'b1;
            go_lo = lo_q;
            go_hi = ad;
            st_d  = TRK_IDLE;
         end
         default: st_d = TRK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= TRK_IDLE;
         lo_q <= '0;
      end else begin
         st_q <= st_d;
         if (first_dual) lo_q <= ad;
      end
   end

endmodule

// File: rtl/pci_cmd_filter.sv
module pci_cmd_filter
   import pci_dec_pkg::*;
#(
   parameter bit SECONDARY = 1'b0
) (
   input  logic [CMD_W-1:0] cmd,
   input  logic [1:0]       lo2,
   output verdict_t         verdict
);

   cmd_class_e cls;
   logic       cfg_ok;
   logic       linear;

   assign cls    = classify(cmd);
   assign linear = (lo2 == 2'b00);

   generate
      if (SECONDARY) begin : g_sec_cfg
         // only forwarded configuration (Type 1) is accepted here
         assign cfg_ok = (lo2 == 2'b01);
      end else begin : g_pri_cfg
         assign cfg_ok = (lo2 == 2'b00) || (lo2 == 2'b01);
      end
   endgenerate

   always_comb begin
      verdict = '0;
      case (cls)
         CLS_IO:  verdict.claim = 1'b1;
         CLS_MEM: begin
            verdict.claim = 1'b1;
            verdict.disc  = !linear;
         end
         CLS_CFG: begin
            verdict.claim  = cfg_ok;
            verdict.cfg_t1 = (lo2 == 2'b01);
         end
         default: verdict = '0;
      endcase
   end

endmodule

// File: rtl/pci_addr_decode.sv
module pci_addr_decode
   import pci_dec_pkg::*;
#(
   parameter int AD_W      = 32,
   parameter bit SECONDARY = 1'b0,
   localparam int ADDR_W   = 2 * AD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [AD_W-1:0]   ad,
   input  logic [3:0]        cbe_n,
   output logic              res_valid,
   output logic              res_claim,
   output logic [3:0]        res_cmd,
   output logic [ADDR_W-1:0] res_addr,
   output logic              res_cfg_t1,
   output logic              res_disc
);

   generate
      if (AD_W < 8 || (AD_W % 8) != 0) begin : g_bad_width
         $error("pci_addr_decode: AD_W must be a multiple of 8, at least 8");
      end
   endgenerate

   logic             go;
   logic [CMD_W-1:0] go_cmd;
   logic [AD_W-1:0]  go_lo;
   logic [AD_W-1:0]  go_hi;
   verdict_t         verdict;

   pci_phase_track #(.AD_W(AD_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .frame_n (frame_n),
      .ad      (ad),
      .cbe_n   (cbe_n),
      .go      (go),
      .go_cmd  (go_cmd),
      .go_lo   (go_lo),
      .go_hi   (go_hi)
   );

   pci_cmd_filter #(.SECONDARY(SECONDARY)) u_filter (
      .cmd     (go_cmd),
      .lo2     (go_lo[1:0]),
      .verdict (verdict)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_claim  <= 1'b0;
         res_cmd    <= '0;
         res_addr   <= '0;
         res_cfg_t1 <= 1'b0;
         res_disc   <= 1'b0;
      end else begin
         res_valid <= go;
         if (go) begin
            res_claim  <= verdict.claim;
            res_cmd    <= go_cmd;
            res_addr   <= {go_hi, go_lo};
            res_cfg_t1 <= verdict.cfg_t1;
            res_disc   <= verdict.disc;
         end else begin
            res_claim  <= 1'b0;
            res_cfg_t1 <= 1'b0;
            res_disc   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pci_addr_decode_chk.sv
module pci_addr_decode_chk #(
   parameter int AD_W      = 32,
   parameter bit SECONDARY = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_n,
   input logic [AD_W-1:0]   ad,
   input logic [3:0]        cbe_n,
   input logic              res_valid,
   input logic              res_claim,
   input logic [3:0]        res_cmd,
   input logic [2*AD_W-1:0] res_addr,
   input logic              res_cfg_t1,
   input logic              res_disc
);

   logic f_q;
   logic pend;
   logic mem_cmd;

   always_ff @(posedge clk) f_q <= frame_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= !pend && f_q && !frame_n && (cbe_n == 4'hD);
   end

   assign mem_cmd = (res_cmd == 4'h6) || (res_cmd == 4'h7) || (res_cmd == 4'hC) ||
                    (res_cmd == 4'hE) || (res_cmd == 4'hF);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (!res_claim && !res_disc && !res_cfg_t1));

   // R2
   single_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && f_q && !frame_n && cbe_n != 4'hD) |=>
         (res_valid && res_cmd == $past(cbe_n) &&
          res_addr == {{AD_W{1'b0}}, $past(ad)}));

   // R3
   dual_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend |=> (res_valid && res_cmd == $past(cbe_n) &&
                res_addr[2*AD_W-1:AD_W] == $past(ad)));

   // R4
   pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   // R5
   reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_cmd == 4'h4 || res_cmd == 4'h5 ||
                     res_cmd == 4'h8 || res_cmd == 4'h9)) |-> !res_claim);

   // R6
   intack_special_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_cmd[3:1] == 3'b000) |-> !res_claim);

   // R8
   cfg_type0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && SECONDARY && res_cmd[3:1] == 3'b101 &&
       res_addr[1:0] == 2'b00) |-> !res_claim);

   // R9
   disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_disc |-> (mem_cmd && res_addr[1:0] != 2'b00));

   // R10
   dual_again_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_cmd == 4'hD) |-> !res_claim);

endmodule

bind pci_addr_decode pci_addr_decode_chk #(.AD_W(AD_W), .SECONDARY(SECONDARY)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_n    (frame_n),
   .ad         (ad),
   .cbe_n      (cbe_n),
   .res_valid  (res_valid),
   .res_claim  (res_claim),
   .res_cmd    (res_cmd),
   .res_addr   (res_addr),
   .res_cfg_t1 (res_cfg_t1),
   .res_disc   (res_disc)
);

// File: tb/pci_addr_decode_test.sv
`timescale 1ns/1ps
module pci_addr_decode_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe_n = '0;

   logic        p_valid, p_claim, p_t1, p_disc;
   logic [3:0]  p_cmd;
   logic [63:0] p_addr;
   logic        s_valid, s_claim, s_t1, s_disc;
   logic [3:0]  s_cmd;
   logic [63:0] s_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pci_addr_decode #(.AD_W(32), .SECONDARY(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
      .res_valid(p_valid), .res_claim(p_claim), .res_cmd(p_cmd),
      .res_addr(p_addr), .res_cfg_t1(p_t1), .res_disc(p_disc));

   pci_addr_decode #(.AD_W(32), .SECONDARY(1'b1)) uut_sec (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ad(ad), .cbe_n(cbe_n),
      .res_valid(s_valid), .res_claim(s_claim), .res_cmd(s_cmd),
      .res_addr(s_addr), .res_cfg_t1(s_t1), .res_disc(s_disc));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic bit is_mem(input logic [3:0] c);
      return c == 4'h6 || c == 4'h7 || c == 4'hC || c == 4'hE || c == 4'hF;
   endfunction

   function automatic bit is_cfg(input logic [3:0] c);
      return c == 4'hA || c == 4'hB;
   endfunction

   function automatic bit exp_claim(input logic [3:0] c, input logic [1:0] lo, input bit sec);
      if (is_mem(c) || c == 4'h2 || c == 4'h3) return 1'b1;
      if (is_cfg(c)) return sec ? (lo == 2'b01) : (lo == 2'b00 || lo == 2'b01);
      return 1'b0;
   endfunction

   function automatic string claim_req(input logic [3:0] c);
      if (c == 4'h4 || c == 4'h5 || c == 4'h8 || c == 4'h9) return "R5 reserved";
      if (c == 4'h0 || c == 4'h1) return "R6 intack/special";
      if (is_cfg(c)) return "R8 config";
      if (c == 4'hD) return "R10 dual in second phase";
      return "R7 io/mem";
   endfunction

   task automatic check_results(input string req, input logic [3:0] c, input logic [63:0] a);
      chk({req, " valid primary"},   {63'd0, p_valid}, 64'd1);
      chk({req, " valid secondary"}, {63'd0, s_valid}, 64'd1);
      chk({req, " cmd"},             {60'd0, p_cmd}, {60'd0, c});
      chk({req, " addr primary"},    p_addr, a);
      chk({req, " addr secondary"},  s_addr, a);
      chk({claim_req(c), " claim primary"},   {63'd0, p_claim}, {63'd0, exp_claim(c, a[1:0], 1'b0)});
      chk({claim_req(c), " claim secondary"}, {63'd0, s_claim}, {63'd0, exp_claim(c, a[1:0], 1'b1)});
      chk("R8 cfg type flag", {63'd0, p_t1}, {63'd0, is_cfg(c) && a[1:0] == 2'b01});
      chk("R9 disconnect flag", {63'd0, p_disc}, {63'd0, is_mem(c) && a[1:0] != 2'b00});
      chk("R9 disconnect flag secondary", {63'd0, s_disc}, {63'd0, is_mem(c) && a[1:0] != 2'b00});
   endtask

   task automatic run_single(input logic [3:0] c, input logic [31:0] a);
      @(negedge clk);
      frame_n = 1'b0; ad = a; cbe_n = c;
      @(negedge clk);
      check_results("R2 single", c, {32'd0, a});
      frame_n = 1'b1; ad = ~a; cbe_n = 4'h0;
      @(negedge clk);
      chk("R4 one-clock pulse", {63'd0, p_valid | s_valid}, 64'd0);
   endtask

   task automatic run_dual(input logic [3:0] c, input logic [31:0] lo, input logic [31:0] hi);
      @(negedge clk);
      frame_n = 1'b0; ad = lo; cbe_n = 4'hD;
      @(negedge clk);
      chk("R3 no pulse after first phase", {63'd0, p_valid | s_valid}, 64'd0);
      ad = hi; cbe_n = c;
      @(negedge clk);
      check_results("R3 dual", c, {hi, lo});
      frame_n = 1'b1; ad = 32'h0; cbe_n = 4'h0;
      @(negedge clk);
      chk("R4 one-clock pulse", {63'd0, p_valid | s_valid}, 64'd0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // frame held low throughout reset and past its release
      repeat (4) @(negedge clk);
      chk("R1 reset valid", {63'd0, p_valid}, 64'd0);
      chk("R1 reset addr", p_addr, 64'd0);
      chk("R1 reset claim", {63'd0, p_claim | s_claim}, 64'd0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk("R1 low frame across reset ignored", {63'd0, p_valid | s_valid}, 64'd0);
      end
      frame_n = 1'b1;
      @(negedge clk);

      for (int c = 0; c < 16; c++) begin
         if (c == 13) continue;
         for (int lo = 0; lo < 4; lo++)
            run_single(4'(c), {8'(c), 8'hA5, 8'(lo * 17), 6'(c), 2'(lo)});
      end

      for (int c = 0; c < 16; c++)
         for (int lo = 0; lo < 4; lo++)
            run_dual(4'(c), {8'h3C, 8'(c), 14'(lo * 77), 2'(lo)}, {4'(c), 28'h9ABCDEF} ^ 32'(lo));

      // frame held low for several clocks: a single pulse only
      @(negedge clk);
      frame_n = 1'b0; ad = 32'h1000_0000; cbe_n = 4'h6;
      @(negedge clk);
      chk("R4 first pulse", {63'd0, p_valid}, 64'd1);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R4 no retrigger while frame low", {63'd0, p_valid | s_valid}, 64'd0);
      end
      frame_n = 1'b1;
      @(negedge clk);
      run_single(4'h7, 32'h2000_0004);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule